// File: doc/BRIEF.md
# Packed Saturating Doubling Multiply-High Unit

This block is a SIMD datapath for signed fixed-point multiplication. For every signed lane it multiplies the two operands and doubles the product. It then keeps the upper half, discarding the lower half without rounding. This is the usual Q15 and Q31 fractional multiply. Only one operand pair can overflow: both inputs at the most negative value. The block clamps that lane to the largest positive value and records the event in a sticky saturation flag.

The result path is combinational from the operand buses to `res_o`. The only register is the sticky flag, which updates on the clock edge when `op_valid_i` marks a real operation. The lane size is 16 or 32 bits. The width select chooses either one 64-bit half or two 64-bit halves that work alike. A scalar mode takes one element from the low 64 bits of the second operand and broadcasts it to every lane. The decoder has three lane modes: MODE_H (16-bit lanes), MODE_W (32-bit lanes) and MODE_BAD (illegal size code). The sticky flag has two states, clear and set. It moves from clear to set on a valid, legal, saturating operation. It moves from set to clear on `sat_clr_i`, unless the same edge carries a saturating operation.

Top module: `sdmh_unit`

## Requirements
- R1: With `lane_sz_i` = 01, each 64-bit half is four 16-bit signed lanes. With `lane_sz_i` = 10, it is two 32-bit signed lanes. Lane k occupies bits [k*W +: W] of its half. Each lane result is floor(2*a*b / 2^W), truncated and not rounded.
- R2: A lane saturates only when both of its inputs equal the most negative value of width W. Its result is then 2^(W-1)-1 (0x7FFF or 0x7FFFFFFF).
- R3: On a clock edge with `op_valid_i` = 1 and a legal size, any saturated lane sets `sat_flag_o`. Non-saturating operations never clear it. Edges with `op_valid_i` = 0 never change it, except through the clear input.
- R4: `sat_clr_i` clears `sat_flag_o` on the next clock edge. If that same edge carries a valid saturating operation, the flag ends set.
- R5: With `wide_i` = 1, bits 127:64 are processed exactly like bits 63:0. With `wide_i` = 0, `res_o[127:64]` is zero and the upper operand bits have no effect, including on the flag.
- R6: With `scalar_en_i` = 1, the second operand of every lane in both halves is one element of `src_b_i[63:0]`. For 16-bit lanes the element is at bits [16*idx +: 16], with idx = `lane_idx_i`. For 32-bit lanes it is at bits [32*idx0 +: 32], with idx0 = `lane_idx_i[0]`; `lane_idx_i[1]` is ignored. `src_b_i[127:64]` is ignored.
- R7: Size codes 00 and 11 raise `illegal_o`. The result is then zero and `sat_flag_o` does not change.
- R8: During and right after reset, `sat_flag_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid_i | input | 1 | Operation presented this cycle; qualifies the flag update |
| lane_sz_i | input | 2 | Lane size code: 01 = 16-bit, 10 = 32-bit, 00 and 11 illegal |
| wide_i | input | 1 | 1 = 128-bit operation, 0 = 64-bit operation |
| scalar_en_i | input | 1 | Broadcast one element of src_b_i as the second operand |
| lane_idx_i | input | 2 | Element index for scalar mode |
| sat_clr_i | input | 1 | Synchronous clear of the sticky flag |
| src_a_i | input | 128 | First operand vector |
| src_b_i | input | 128 | Second operand vector, or the scalar source in its low 64 bits |
| res_o | output | 128 | Result vector |
| sat_flag_o | output | 1 | Sticky cumulative saturation flag |
| illegal_o | output | 1 | Illegal lane size code |

## Verification
On every cycle the assertions check these properties:
- An illegal size forces a zero result and leaves the flag unchanged.
- A narrow operation leaves the upper result half at zero.
- The flag never falls without a clear and never rises without a valid operation.
- A 16-bit lane with both inputs at the most negative value returns the clamped maximum.

Only the bench scenarios can show the exact truncated values of every lane. The same holds for the scalar element selection and broadcast, the clear-versus-set priority and the isolation of the ignored operand bits. The bench compares these against a full-width arithmetic reference.

// File: rtl/sdmh_pkg.sv
package sdmh_pkg;
    localparam int HALF_W   = 64;
    localparam int VEC_W    = 128;
    localparam int NARROW_W = 16;
    localparam int WIDE_W   = 32;
    localparam int IDX_W    = $clog2(HALF_W / NARROW_W);

    typedef enum logic [1:0] {
        MODE_BAD = 2'd0,
        MODE_H   = 2'd1,
        MODE_W   = 2'd2
    } lane_mode_e;

    function automatic lane_mode_e decode_size(input logic [1:0] code);
        lane_mode_e m;
        unique case (code)
            2'b01:   m = MODE_H;
            2'b10:   m = MODE_W;
            default: m = MODE_BAD;
        endcase
        return m;
    endfunction
endpackage

// File: rtl/sdmh_lane.sv
module sdmh_lane #(
    parameter int W = 16
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] y_o,
    output logic         sat_o
);
    localparam logic [W-1:0] MIN_V = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] MAX_V = {1'b0, {(W-1){1'b1}}};

    logic signed [2*W-1:0] ax, bx, prod;

    always_comb begin
        ax    = {{W{a_i[W-1]}}, a_i};
        bx    = {{W{b_i[W-1]}}, b_i};
        prod  = ax * bx;
        sat_o = (a_i == MIN_V) && (b_i == MIN_V);
        // doubling then taking the high half equals bits [2W-2:W-1] of the product
        y_o   = sat_o ? MAX_V : prod[2*W-2:W-1];
    end
endmodule

// File: rtl/sdmh_half.sv
module sdmh_half
    import sdmh_pkg::*;
#(
    parameter int HW = HALF_W,
    parameter int NW = NARROW_W,
    parameter int WW = WIDE_W
) (
    input  logic [HW-1:0] a_i,
    input  logic [HW-1:0] b_i,
    input  lane_mode_e    mode_i,
    output logic [HW-1:0] y_o,
    output logic          sat_o
);
    localparam int NL = HW / NW;
    localparam int WL = HW / WW;

    logic [HW-1:0] y_n, y_w;
    logic [NL-1:0] sat_n;
    logic [WL-1:0] sat_w;

    for (genvar k = 0; k < NL; k++) begin : g_narrow
        sdmh_lane #(.W(NW)) lane_i (
            .a_i  (a_i[k*NW +: NW]),
            .b_i  (b_i[k*NW +: NW]),
            .y_o  (y_n[k*NW +: NW]),
            .sat_o(sat_n[k])
        );
    end

    for (genvar k = 0; k < WL; k++) begin : g_wide
        sdmh_lane #(.W(WW)) lane_i (
            .a_i  (a_i[k*WW +: WW]),
            .b_i  (b_i[k*WW +: WW]),
            .y_o  (y_w[k*WW +: WW]),
            .sat_o(sat_w[k])
        );
    end

    always_comb begin
        unique case (mode_i)
            MODE_H: begin
                y_o   = y_n;
                sat_o = |sat_n;
            end
            MODE_W: begin
                y_o   = y_w;
                sat_o = |sat_w;
            end
            default: begin
                y_o   = '0;
                sat_o = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/sdmh_bsel.sv
module sdmh_bsel
    import sdmh_pkg::*;
#(
    parameter int VW = VEC_W,
    parameter int HW = HALF_W,
    parameter int NW = NARROW_W,
    parameter int WW = WIDE_W,
    parameter int IW = IDX_W
) (
    input  logic [VW-1:0] b_i,
    input  logic          scalar_en_i,
    input  lane_mode_e    mode_i,
    input  logic [IW-1:0] idx_i,
    output logic [VW-1:0] b_eff_o
);
    localparam int NR = VW / NW;
    localparam int WR = VW / WW;

    logic [HW-1:0] low;
    logic [NW-1:0] el_n;
    logic [WW-1:0] el_w;
    logic [VW-1:0] rep_n, rep_w;

    always_comb begin
        low  = b_i[HW-1:0];
        el_n = low[int'(idx_i) * NW +: NW];
        el_w = low[int'(idx_i[0]) * WW +: WW];
        for (int k = 0; k < NR; k++) rep_n[k*NW +: NW] = el_n;
        for (int k = 0; k < WR; k++) rep_w[k*WW +: WW] = el_w;
        if (!scalar_en_i) begin
            b_eff_o = b_i;
        end else begin
            unique case (mode_i)
                MODE_H:  b_eff_o = rep_n;
                MODE_W:  b_eff_o = rep_w;
                default: b_eff_o = '0;
            endcase
        end
    end
endmodule

// File: rtl/sdmh_unit.sv
module sdmh_unit
    import sdmh_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid_i,
    input  logic [1:0]        lane_sz_i,
    input  logic              wide_i,
    input  logic              scalar_en_i,
    input  logic [IDX_W-1:0]  lane_idx_i,
    input  logic              sat_clr_i,
    input  logic [VEC_W-1:0]  src_a_i,
    input  logic [VEC_W-1:0]  src_b_i,
    output logic [VEC_W-1:0]  res_o,
    output logic              sat_flag_o,
    output logic              illegal_o
);
    localparam int HALVES = VEC_W / HALF_W;

    lane_mode_e         mode;
    logic [VEC_W-1:0]   b_eff;
    logic [VEC_W-1:0]   y_all;
    logic [HALVES-1:0]  sat_h;
    logic [HALVES-1:0]  half_en;
    logic               sat_any;
    logic               flag_q, flag_d;

    always_comb mode = decode_size(lane_sz_i);

    sdmh_bsel #(
        .VW(VEC_W), .HW(HALF_W), .NW(NARROW_W), .WW(WIDE_W), .IW(IDX_W)
    ) bsel_i (
        .b_i        (src_b_i),
        .scalar_en_i(scalar_en_i),
        .mode_i     (mode),
        .idx_i      (lane_idx_i),
        .b_eff_o    (b_eff)
    );

    for (genvar h = 0; h < HALVES; h++) begin : g_half
        logic [HALF_W-1:0] y_h;
        logic              s_h;

        sdmh_half #(.HW(HALF_W), .NW(NARROW_W), .WW(WIDE_W)) half_i (
            .a_i   (src_a_i[h*HALF_W +: HALF_W]),
            .b_i   (b_eff[h*HALF_W +: HALF_W]),
            .mode_i(mode),
            .y_o   (y_h),
            .sat_o (s_h)
        );

        always_comb begin
            half_en[h] = (h == 0) || wide_i;
            y_all[h*HALF_W +: HALF_W] = half_en[h] ? y_h : '0;
            sat_h[h] = half_en[h] && s_h;
        end
    end

    always_comb begin
        illegal_o = (mode == MODE_BAD);
        res_o     = illegal_o ? '0 : y_all;
        sat_any   = op_valid_i && !illegal_o && (|sat_h);
        flag_d    = (sat_clr_i ? 1'b0 : flag_q) | sat_any;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    always_comb sat_flag_o = flag_q;
endmodule

// File: rtl/sdmh_unit_chk.sv
module sdmh_unit_chk
    import sdmh_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              op_valid_i,
    input logic [1:0]        lane_sz_i,
    input logic              wide_i,
    input logic              scalar_en_i,
    input logic              sat_clr_i,
    input logic [VEC_W-1:0]  src_a_i,
    input logic [VEC_W-1:0]  src_b_i,
    input logic [VEC_W-1:0]  res_o,
    input logic              sat_flag_o,
    input logic              illegal_o
);
    localparam logic [NARROW_W-1:0] NMIN = {1'b1, {(NARROW_W-1){1'b0}}};
    localparam logic [NARROW_W-1:0] NMAX = {1'b0, {(NARROW_W-1){1'b1}}};

    // R7
    illegal_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> (res_o == '0));

    // R7
    illegal_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (illegal_o && !sat_clr_i) |=> (sat_flag_o == $past(sat_flag_o)));

    // R5
    narrow_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wide_i |-> (res_o[VEC_W-1:HALF_W] == '0));

    // R3
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_flag_o && !sat_clr_i) |=> sat_flag_o);

    // R3
    flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sat_flag_o && !op_valid_i) |=> !sat_flag_o);

    // R4
    flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_clr_i && !op_valid_i) |=> !sat_flag_o);

    // R2
    sat_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_sz_i == 2'b01 && !scalar_en_i && src_a_i[NARROW_W-1:0] == NMIN
         && src_b_i[NARROW_W-1:0] == NMIN) |-> (res_o[NARROW_W-1:0] == NMAX));
endmodule

bind sdmh_unit sdmh_unit_chk chk_i (.*);

// File: tb/sdmh_unit_tb_top.sv
module sdmh_unit_tb_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         op_valid_i = 1'b0;
    logic [1:0]   lane_sz_i = 2'b00;
    logic         wide_i = 1'b0;
    logic         scalar_en_i = 1'b0;
    logic [1:0]   lane_idx_i = 2'b00;
    logic         sat_clr_i = 1'b0;
    logic [127:0] src_a_i = '0;
    logic [127:0] src_b_i = '0;
    logic [127:0] res_o;
    logic         sat_flag_o;
    logic         illegal_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit exp_flag = 1'b0;

    always #2 clk = ~clk;

    sdmh_unit dut_i (.*);

    function automatic longint sx(input logic [127:0] v, input int pos, input int w);
        logic [127:0] sh;
        sh = v >> pos;
        if (w == 16) return longint'($signed(sh[15:0]));
        return longint'($signed(sh[31:0]));
    endfunction

    function automatic logic [127:0] model(input logic [127:0] a, input logic [127:0] b,
            input logic [1:0] sz, input bit wide, input bit scal, input logic [1:0] idx,
            output bit sat);
        logic [127:0] out;
        int w, lanes, halves, bpos;
        longint av, bv, p, r, mx, mask;
        out = '0;
        sat = 1'b0;
        if (sz == 2'b00 || sz == 2'b11) return out;
        w      = (sz == 2'b01) ? 16 : 32;
        lanes  = 64 / w;
        halves = wide ? 2 : 1;
        mx     = (longint'(1) <<< (w - 1)) - 1;
        mask   = (longint'(1) <<< w) - 1;
        for (int h = 0; h < halves; h++) begin
            for (int k = 0; k < lanes; k++) begin
                int pos;
                pos = h * 64 + k * w;
                if (scal) bpos = (w == 16) ? int'(idx) * 16 : int'(idx[0]) * 32;
                else      bpos = pos;
                av = sx(a, pos, w);
                bv = sx(b, bpos, w);
                p  = av * bv;
                r  = p >>> (w - 1);
                if (r > mx) begin
                    r = mx;
                    sat = 1'b1;
                end
                out = out | (128'(r & mask) << pos);
            end
        end
        return out;
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic run_op(input logic [127:0] a, input logic [127:0] b, input logic [1:0] sz,
                          input bit wide, input bit scal, input logic [1:0] idx,
                          input bit clr, input bit vld, input string tag);
        logic [127:0] er;
        bit s, ill;
        @(negedge clk);
        src_a_i = a; src_b_i = b; lane_sz_i = sz; wide_i = wide;
        scalar_en_i = scal; lane_idx_i = idx; sat_clr_i = clr; op_valid_i = vld;
        #1;
        er  = model(a, b, sz, wide, scal, idx, s);
        ill = (sz == 2'b00 || sz == 2'b11);
        check(res_o === er, tag, "result", res_o, er);
        check(illegal_o === ill, tag, "illegal", 128'(illegal_o), 128'(ill));
        @(posedge clk);
        if (clr) exp_flag = 1'b0;
        if (vld && s) exp_flag = 1'b1;
        #1;
        check(sat_flag_o === exp_flag, tag, "flag", 128'(sat_flag_o), 128'(exp_flag));
    endtask

    function automatic logic [31:0] corner(input int i, input int w);
        logic [31:0] v;
        case (i % 8)
            0: v = 32'h8000_0000;
            1: v = 32'h8000_0001;
            2: v = 32'hFFFF_FFFF;
            3: v = 32'h0000_0000;
            4: v = 32'h0000_0001;
            5: v = 32'h7FFF_FFFF;
            6: v = 32'h4000_0000;
            default: v = 32'hC000_0000;
        endcase
        if (w == 16) v = {16'h0, v[31:16] | ((i % 8 == 4) ? 16'h0001 : 16'h0000)};
        return v;
    endfunction

    function automatic logic [127:0] build(input int s0, input int step, input int w);
        logic [127:0] v;
        v = '0;
        for (int k = 0; k < 128 / w; k++)
            v = v | (128'(corner(s0 + step * k, w) & ((w == 16) ? 32'hFFFF : 32'hFFFF_FFFF)) << (k * w));
        return v;
    endfunction

    initial begin
        #(4 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [127:0] mn16, mn32;
        mn16 = {8{16'h8000}};
        mn32 = {4{32'h8000_0000}};
        repeat (2) @(posedge clk);
        #1;
        // R8: reset state
        check(sat_flag_o === 1'b0, "R8", "flag in reset", 128'(sat_flag_o), 128'(0));
        rst_n = 1'b1;
        @(negedge clk);
        check(sat_flag_o === 1'b0, "R8", "flag after reset", 128'(sat_flag_o), 128'(0));

        // R1 R2 R3 R5: corner sweep, both sizes and widths
        for (int w = 16; w <= 32; w += 16)
            for (int i = 0; i < 8; i++)
                for (int j = 0; j < 8; j++)
                    run_op(build(i, 1, w), build(j, 3, w), (w == 16) ? 2'b01 : 2'b10,
                           bit'((i + j) % 2), 1'b0, 2'b00, (j == 0), 1'b1, "R1/R2");

        // R6: scalar broadcast over every index, idx bit 1 ignored for 32-bit lanes
        for (int w = 16; w <= 32; w += 16)
            for (int i = 0; i < 8; i++)
                for (int x = 0; x < 4; x++)
                    run_op(build(i, 1, w), build(i + x, 5, w) ^ {64'hDEAD_BEEF_1234_5678, 64'h0},
                           (w == 16) ? 2'b01 : 2'b10, bit'(x % 2), 1'b1, 2'(x), 1'b1, 1'b1, "R6");

        // R7: illegal sizes with saturating inputs leave the flag alone
        run_op('0, '0, 2'b01, 1'b1, 1'b0, 2'b00, 1'b1, 1'b1, "R7");
        run_op(mn16, mn16, 2'b00, 1'b1, 1'b0, 2'b00, 1'b0, 1'b1, "R7");
        run_op(mn32, mn32, 2'b11, 1'b1, 1'b1, 2'b00, 1'b0, 1'b1, "R7");
        run_op(mn16, mn16, 2'b01, 1'b0, 1'b0, 2'b00, 1'b0, 1'b1, "R7");
        run_op('0, '0, 2'b11, 1'b1, 1'b0, 2'b00, 1'b0, 1'b1, "R7");

        // R3: no update without op_valid
        run_op(mn16, mn16, 2'b01, 1'b1, 1'b0, 2'b00, 1'b1, 1'b0, "R3");
        run_op(mn32, mn32, 2'b10, 1'b1, 1'b0, 2'b00, 1'b0, 1'b0, "R3");
        run_op('0, '0, 2'b10, 1'b1, 1'b0, 2'b00, 1'b0, 1'b1, "R3");

        // R4: clear and saturation on the same edge leaves the flag set
        run_op(mn32, mn32, 2'b10, 1'b0, 1'b0, 2'b00, 1'b1, 1'b1, "R4");
        run_op('0, '0, 2'b10, 1'b0, 1'b0, 2'b00, 1'b1, 1'b1, "R4");

        // R5: saturating pairs only in the upper half while narrow
        run_op({64'h8000_8000_8000_8000, 64'h1}, {64'h8000_8000_8000_8000, 64'h3},
               2'b01, 1'b0, 1'b0, 2'b00, 1'b1, 1'b1, "R5");
        run_op({64'h8000_0000_8000_0000, 64'h5}, {64'h8000_0000_8000_0000, 64'h7},
               2'b10, 1'b0, 1'b0, 2'b00, 1'b0, 1'b1, "R5");

        // R1 R6: random mix
        for (int n = 0; n < 3000; n++)
            run_op({$urandom, $urandom, $urandom, $urandom}, {$urandom, $urandom, $urandom, $urandom},
                   2'($urandom), 1'($urandom), 1'($urandom), 2'($urandom),
                   ($urandom % 16) == 0, 1'($urandom), "R1/R6");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule